// File: doc/BRIEF.md
# Branch Target Address Unit

This unit works out where an 8-bit microcontroller core goes next after a control-transfer instruction in a 16-bit code space. The decoder hands it one item per instruction. Each item carries a branch class code, the opcode byte, up to two operand bytes, the address of the opcode, the accumulator, the 16-bit data pointer, the carry flag, the value of a tested bit, and a register value. The register value is the counter for loop branches and the first operand for compare branches. The unit returns the next program counter and a taken flag. For loop and compare forms it also returns the write-back values for the register and the carry. It flags bit clears and subroutine calls as well.

Items flow on a valid/ready stream, and results come back on a second valid/ready stream through one output register. An item is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value. A result appears on the outputs one clock after its item is accepted, and a full-rate flow with `out_ready` tied high sustains one item per clock.

Top module: `brtgt_unit`

## Requirements
- R1: Class codes on `in_class` are: 0 none, 1 page-absolute, 2 long, 3 short relative, 4 indexed, 5 branch-if-acc-zero, 6 branch-if-acc-nonzero, 7 branch-if-carry, 8 branch-if-no-carry, 9 branch-if-bit-set, 10 branch-if-bit-clear, 11 branch-if-bit-set-then-clear, 12 register loop, 13 direct-address loop, 14 compare. Code 15 behaves like 0. A not-taken item yields `in_pc` plus its length, modulo 65536.
- R2: Instruction lengths are as follows. None and indexed are 1 byte. Page-absolute, short relative, the four accumulator and carry tests, and the register loop are 2 bytes. Long, the three bit tests, the direct-address loop and compare are 3 bytes.
- R3: A page-absolute target takes bits 15:11 from `in_pc`+2, bits 10:8 from opcode bits 7:5 and bits 7:0 from `in_op1`. `out_call` is high for page-absolute and long items whose opcode bit 4 is 1, and low otherwise.
- R4: A long target is `{in_op1, in_op2}`: `in_op1` is the high byte.
- R5: A relative target is `in_pc` + length + the signed 8-bit offset, wrapping modulo 65536. The offset is `in_op2` for 3-byte forms and `in_op1` for 2-byte forms.
- R6: An indexed target is `in_dptr` + the unsigned `in_acc`, modulo 65536.
- R7: Classes 5 and 6 branch when `in_acc` is zero and nonzero respectively. Classes 7 and 8 branch when `in_carry` is 1 and 0 respectively.
- R8: Classes 9 and 11 branch when `in_bit` is 1, and class 10 branches when it is 0. `out_bit_clr` is 1 only for class 11 when the branch is taken.
- R9: Loop classes return `out_regv` = `in_regv`-1 (0 wraps to 255) with `out_reg_we`=1, and branch only when that new value is nonzero.
- R10: Compare branches when `in_regv` differs from `in_op1`. It returns `out_carry_we`=1 with `out_carry` = (`in_regv` < `in_op1`, unsigned). All other classes return `out_carry_we`=0 and `out_reg_we`=0.
- R11: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, all outputs hold, and results leave in acceptance order.
- R12: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Item offered |
| in_ready | output | 1 | Item can be taken this cycle |
| in_class | input | 4 | Branch class code (R1) |
| in_opcode | input | 8 | Opcode byte |
| in_op1 | input | 8 | First operand byte |
| in_op2 | input | 8 | Second operand byte |
| in_pc | input | 16 | Address of the opcode |
| in_acc | input | 8 | Accumulator |
| in_dptr | input | 16 | Data pointer |
| in_carry | input | 1 | Carry flag |
| in_bit | input | 1 | Value of the tested bit |
| in_regv | input | 8 | Loop counter or first compare operand |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_npc | output | 16 | Next program counter |
| out_taken | output | 1 | Branch taken |
| out_call | output | 1 | Return address must be saved |
| out_regv | output | 8 | Register write-back value |
| out_reg_we | output | 1 | Register write-back enable |
| out_carry | output | 1 | Carry write-back value |
| out_carry_we | output | 1 | Carry write-back enable |
| out_bit_clr | output | 1 | Clear the tested bit |

## Verification
The assertions check four things on every cycle. Outputs must hold while stalled. A bit clear or a call must never come without a taken branch. A loop result's taken flag must agree with its new counter. A compare that sets carry must also branch. Only the bench scenarios can show that target arithmetic is correct. These cover page boundaries crossed by the following address, backward offsets that wrap below zero, indexed sums that wrap past 65535, counters that wrap from 0 to 255, and compare operands that are equal, lower or higher. The scenarios also show that ordering is preserved under a recurring back-pressure pattern.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;
  parameter int CODE_AW = 16;
  parameter int BYTE_W  = 8;
  parameter int PAGE_AW = 11;
  localparam int PAGE_SEL_W = PAGE_AW - BYTE_W;
  localparam int LEN_W      = 2;
  localparam int CLASS_W    = 4;

  typedef enum logic [CLASS_W-1:0] {
    BC_NONE  = 4'd0,
    BC_ABS   = 4'd1,
    BC_LONG  = 4'd2,
    BC_SREL  = 4'd3,
    BC_INDIR = 4'd4,
    BC_AZ    = 4'd5,
    BC_ANZ   = 4'd6,
    BC_CY    = 4'd7,
    BC_NCY   = 4'd8,
    BC_BSET  = 4'd9,
    BC_BCLR  = 4'd10,
    BC_BSETC = 4'd11,
    BC_LOOPR = 4'd12,
    BC_LOOPD = 4'd13,
    BC_CMP   = 4'd14,
    BC_RSVD  = 4'd15
  } br_class_e;

  typedef struct packed {
    logic [CODE_AW-1:0] npc;
    logic               taken;
    logic               call;
    logic [BYTE_W-1:0]  reg_val;
    logic               reg_we;
    logic               carry;
    logic               carry_we;
    logic               bit_clr;
  } br_result_t;
endpackage

// File: rtl/brtgt_decode.sv
module brtgt_decode
  import brtgt_pkg::*;
(
  input  br_class_e                cls,
  input  logic [BYTE_W-1:0]        opcode,
  input  logic [BYTE_W-1:0]        op1,
  input  logic [BYTE_W-1:0]        op2,
  output logic [LEN_W-1:0]         len,
  output logic [BYTE_W-1:0]        rel_off,
  output logic                     rel_mode,
  output logic                     call
);
  localparam int CALL_BIT = 4;

  always_comb begin
    len      = LEN_W'(1);
    rel_off  = op1;
    rel_mode = 1'b0;
    call     = 1'b0;
    unique case (cls)
      BC_ABS: begin
        len  = LEN_W'(2);
        call = opcode[CALL_BIT];
      end
      BC_LONG: begin
        len  = LEN_W'(3);
        call = opcode[CALL_BIT];
      end
      BC_SREL, BC_AZ, BC_ANZ, BC_CY, BC_NCY, BC_LOOPR: begin
        len      = LEN_W'(2);
        rel_mode = 1'b1;
      end
      BC_BSET, BC_BCLR, BC_BSETC, BC_LOOPD, BC_CMP: begin
        len      = LEN_W'(3);
        rel_off  = op2;
        rel_mode = 1'b1;
      end
      default: len = LEN_W'(1);
    endcase
  end
endmodule

// File: rtl/brtgt_cond.sv
module brtgt_cond
  import brtgt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  br_class_e           cls,
  input  logic [BYTE_W-1:0]   acc,
  input  logic                carry,
  input  logic                bitv,
  input  logic [BYTE_W-1:0]   regv,
  input  logic [BYTE_W-1:0]   cmpv,
  output logic                taken,
  output logic [BYTE_W-1:0]   reg_new,
  output logic                reg_we,
  output logic                carry_new,
  output logic                carry_we,
  output logic                bit_clr
);
  logic [BYTE_W-1:0] dec_val;
  logic              acc_zero;

  assign dec_val  = regv - BYTE_W'(1);
  assign acc_zero = (acc == '0);

  always_comb begin
    taken     = 1'b0;
    reg_new   = regv;
    reg_we    = 1'b0;
    carry_new = carry;
    carry_we  = 1'b0;
    bit_clr   = 1'b0;
    unique case (cls)
      BC_ABS, BC_LONG, BC_SREL, BC_INDIR: taken = 1'b1;
      BC_AZ:    taken = acc_zero;
      BC_ANZ:   taken = !acc_zero;
      BC_CY:    taken = carry;
      BC_NCY:   taken = !carry;
      BC_BSET:  taken = bitv;
      BC_BCLR:  taken = !bitv;
      BC_BSETC: begin
        taken   = bitv;
        bit_clr = bitv;
      end
      BC_LOOPR, BC_LOOPD: begin
        reg_new = dec_val;
        reg_we  = 1'b1;
        taken   = (dec_val != '0);
      end
      BC_CMP: begin
        taken     = (regv != cmpv);
        carry_new = (regv < cmpv);
        carry_we  = 1'b1;
      end
      default: taken = 1'b0;
    endcase
  end

  // R10: an unsigned-lower first operand always differs, so it branches
  assert_cmp_lower_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_we && carry_new) |-> taken);
endmodule

// File: rtl/brtgt_addr.sv
module brtgt_addr
  import brtgt_pkg::*;
(
  input  br_class_e            cls,
  input  logic [BYTE_W-1:0]    opcode,
  input  logic [BYTE_W-1:0]    op1,
  input  logic [BYTE_W-1:0]    op2,
  input  logic [CODE_AW-1:0]   pc,
  input  logic [LEN_W-1:0]     len,
  input  logic [BYTE_W-1:0]    rel_off,
  input  logic                 rel_mode,
  input  logic [BYTE_W-1:0]    acc,
  input  logic [CODE_AW-1:0]   dptr,
  input  logic                 taken,
  output logic [CODE_AW-1:0]   npc
);
  localparam int EXT_W = CODE_AW - BYTE_W;

  logic [CODE_AW-1:0] seq_pc;
  logic [CODE_AW-1:0] rel_pc;
  logic [CODE_AW-1:0] abs_pc;
  logic [CODE_AW-1:0] idx_pc;
  logic [CODE_AW-1:0] long_pc;
  logic [CODE_AW-1:0] off_ext;

  assign seq_pc  = pc + CODE_AW'(len);
  assign off_ext = {{EXT_W{rel_off[BYTE_W-1]}}, rel_off};
  assign rel_pc  = seq_pc + off_ext;
  assign idx_pc  = dptr + CODE_AW'(acc);
  assign long_pc = {op1, op2};

  generate
    if (PAGE_SEL_W > 0) begin : g_paged
      assign abs_pc = {seq_pc[CODE_AW-1:PAGE_AW],
                       opcode[BYTE_W-1 -: PAGE_SEL_W], op1};
    end else begin : g_flat
      assign abs_pc = {seq_pc[CODE_AW-1:BYTE_W], op1};
    end
  endgenerate

  always_comb begin
    npc = seq_pc;
    if (taken) begin
      if (rel_mode) npc = rel_pc;
      else begin
        unique case (cls)
          BC_ABS:   npc = abs_pc;
          BC_LONG:  npc = long_pc;
          BC_INDIR: npc = idx_pc;
          default:  npc = seq_pc;
        endcase
      end
    end
  end
endmodule

// File: rtl/brtgt_unit.sv
module brtgt_unit
  import brtgt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [CLASS_W-1:0]   in_class,
  input  logic [BYTE_W-1:0]    in_opcode,
  input  logic [BYTE_W-1:0]    in_op1,
  input  logic [BYTE_W-1:0]    in_op2,
  input  logic [CODE_AW-1:0]   in_pc,
  input  logic [BYTE_W-1:0]    in_acc,
  input  logic [CODE_AW-1:0]   in_dptr,
  input  logic                 in_carry,
  input  logic                 in_bit,
  input  logic [BYTE_W-1:0]    in_regv,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [CODE_AW-1:0]   out_npc,
  output logic                 out_taken,
  output logic                 out_call,
  output logic [BYTE_W-1:0]    out_regv,
  output logic                 out_reg_we,
  output logic                 out_carry,
  output logic                 out_carry_we,
  output logic                 out_bit_clr
);
  br_class_e         cls;
  logic [LEN_W-1:0]  len;
  logic [BYTE_W-1:0] rel_off;
  logic              rel_mode;
  logic              call;
  br_result_t        nxt;
  br_result_t        held;

  assign cls = br_class_e'(in_class);

  brtgt_decode u_dec (
    .cls(cls), .opcode(in_opcode), .op1(in_op1), .op2(in_op2),
    .len(len), .rel_off(rel_off), .rel_mode(rel_mode), .call(call)
  );

  brtgt_cond u_cond (
    .clk(clk), .rst_n(rst_n), .cls(cls), .acc(in_acc), .carry(in_carry),
    .bitv(in_bit), .regv(in_regv), .cmpv(in_op1),
    .taken(nxt.taken), .reg_new(nxt.reg_val), .reg_we(nxt.reg_we),
    .carry_new(nxt.carry), .carry_we(nxt.carry_we), .bit_clr(nxt.bit_clr)
  );

  brtgt_addr u_addr (
    .cls(cls), .opcode(in_opcode), .op1(in_op1), .op2(in_op2), .pc(in_pc),
    .len(len), .rel_off(rel_off), .rel_mode(rel_mode), .acc(in_acc),
    .dptr(in_dptr), .taken(nxt.taken), .npc(nxt.npc)
  );

  assign nxt.call = call;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      held      <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      held      <= nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_npc      = held.npc;
  assign out_taken    = held.taken;
  assign out_call     = held.call;
  assign out_regv     = held.reg_val;
  assign out_reg_we   = held.reg_we;
  assign out_carry    = held.carry;
  assign out_carry_we = held.carry_we;
  assign out_bit_clr  = held.bit_clr;

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_npc) &&
                                   $stable(out_taken) && $stable(out_regv)));

  assert_clear_needs_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bit_clr) |-> out_taken);

  assert_loop_consistent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_reg_we) |-> (out_taken == (out_regv != '0)));

  assert_call_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_call) |-> (out_taken && !out_reg_we && !out_carry_we));
endmodule

// File: tb/sim_brtgt_unit.sv
module sim_brtgt_unit;
  import brtgt_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_class = '0;
  logic [7:0]  in_opcode = '0, in_op1 = '0, in_op2 = '0, in_acc = '0, in_regv = '0;
  logic [15:0] in_pc = '0, in_dptr = '0;
  logic        in_carry = 1'b0, in_bit = 1'b0;
  logic        out_valid, out_ready = 1'b1;
  logic [15:0] out_npc;
  logic        out_taken, out_call, out_reg_we, out_carry, out_carry_we, out_bit_clr;
  logic [7:0]  out_regv;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit stall_on = 1'b0;

  br_result_t exp_q[$];
  string      tag_q[$];

  brtgt_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_opcode(in_opcode), .in_op1(in_op1), .in_op2(in_op2),
    .in_pc(in_pc), .in_acc(in_acc), .in_dptr(in_dptr), .in_carry(in_carry),
    .in_bit(in_bit), .in_regv(in_regv), .out_valid(out_valid), .out_ready(out_ready),
    .out_npc(out_npc), .out_taken(out_taken), .out_call(out_call), .out_regv(out_regv),
    .out_reg_we(out_reg_we), .out_carry(out_carry), .out_carry_we(out_carry_we),
    .out_bit_clr(out_bit_clr)
  );

  // back-pressure: consumer refuses one cycle in four when enabled (R11)
  always @(posedge clk) begin
    #2;
    cyc = cyc + 1;
    out_ready = !(stall_on && (cyc % 4 == 3));
  end

  // expected result built from the requirement text
  function automatic br_result_t model(int c, int opc, int o1, int o2, int pc,
                                       int acc, int dp, int cy, int b, int rv);
    br_result_t r;
    int ln, off, nxt, tk;
    ln = 1;
    if (c == 1 || c == 3 || (c >= 5 && c <= 8) || c == 12) ln = 2;
    if (c == 2 || (c >= 9 && c <= 11) || c == 13 || c == 14) ln = 3;
    off = (ln == 3) ? o2 : o1;
    if (off > 127) off = off - 256;
    tk = 0;
    r = '0;
    r.reg_val = 8'(rv);
    r.carry   = cy[0];
    case (c)
      1, 2, 3, 4: tk = 1;
      5:  tk = (acc == 0);
      6:  tk = (acc != 0);
      7:  tk = (cy == 1);
      8:  tk = (cy == 0);
      9, 11: tk = (b == 1);
      10: tk = (b == 0);
      12, 13: begin
        r.reg_val = 8'((rv + 255) % 256);
        r.reg_we  = 1'b1;
        tk = (r.reg_val != 0);
      end
      14: begin
        tk = (rv != o1);
        r.carry    = (rv < o1);
        r.carry_we = 1'b1;
      end
      default: tk = 0;
    endcase
    nxt = (pc + ln) % 65536;
    if (tk == 1) begin
      case (c)
        1: nxt = (((pc + 2) % 65536) / 2048) * 2048 + (opc / 32) * 256 + o1;
        2: nxt = o1 * 256 + o2;
        4: nxt = (dp + acc) % 65536;
        default: nxt = (pc + ln + off + 65536) % 65536;
      endcase
    end
    r.npc     = 16'(nxt);
    r.taken   = tk[0];
    r.call    = (c == 1 || c == 2) && ((opc / 16) % 2 == 1);
    r.bit_clr = (c == 11) && (b == 1);
    return r;
  endfunction

  task automatic send(int c, int opc, int o1, int o2, int pc, int acc, int dp,
                      int cy, int b, int rv, string tag);
    @(negedge clk);
    in_class = 4'(c); in_opcode = 8'(opc); in_op1 = 8'(o1); in_op2 = 8'(o2);
    in_pc = 16'(pc); in_acc = 8'(acc); in_dptr = 16'(dp); in_carry = cy[0];
    in_bit = b[0]; in_regv = 8'(rv); in_valid = 1'b1;
    exp_q.push_back(model(c, opc, o1, o2, pc, acc, dp, cy, b, rv));
    tag_q.push_back(tag);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    #3;
    if (rst_n && out_valid && out_ready) begin
      br_result_t act, e;
      string t;
      act = '{out_npc, out_taken, out_call, out_regv, out_reg_we,
              out_carry, out_carry_we, out_bit_clr};
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected result act=%h exp=none", act);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          fails++;
          $display("FAIL %s act=%h exp=%h", t, act, e);
        end
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R11 act=hung exp=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R12 reset act=%b%b exp=01", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R12 idle act=%b exp=0", out_valid);
    end

    // R1 R2: none / reserved classes step by length
    send(0, 8'h00, 0, 0, 16'h1234, 0, 0, 0, 0, 0, "R1 none");
    send(15, 8'hA5, 9, 9, 16'hFFFF, 0, 0, 0, 0, 0, "R1 reserved wrap");
    // R3: page-absolute, page crossing by following address, call flag
    send(1, 8'hE1, 8'h34, 0, 16'h1000, 0, 0, 0, 0, 0, "R3 abs jump");
    send(1, 8'h51, 8'h07, 0, 16'h07FE, 0, 0, 0, 0, 0, "R3 abs call across page");
    send(1, 8'h31, 8'hFF, 0, 16'hF7FF, 0, 0, 0, 0, 0, "R3 abs call high");
    // R4: long jump and call
    send(2, 8'h02, 8'hAB, 8'hCD, 16'h0100, 0, 0, 0, 0, 0, "R4 long jump");
    send(2, 8'h12, 8'h00, 8'h10, 16'hFFFE, 0, 0, 0, 0, 0, "R4 long call");
    // R5: relative forward, backward, wrap
    send(3, 8'h80, 8'h7F, 0, 16'h2000, 0, 0, 0, 0, 0, "R5 rel forward");
    send(3, 8'h80, 8'h80, 0, 16'h0001, 0, 0, 0, 0, 0, "R5 rel backward wrap");
    send(3, 8'h80, 8'hFE, 0, 16'h4000, 0, 0, 0, 0, 0, "R5 rel self");
    // R6: indexed
    send(4, 8'h73, 0, 0, 16'h0000, 8'h02, 16'hFFFF, 0, 0, 0, "R6 indexed wrap");
    send(4, 8'h73, 0, 0, 16'h0000, 8'hFF, 16'h1000, 0, 0, 0, "R6 indexed unsigned");
    // R7: accumulator and carry tests
    send(5, 8'h60, 8'h10, 0, 16'h3000, 8'h00, 0, 0, 0, 0, "R7 az taken");
    send(5, 8'h60, 8'h10, 0, 16'h3000, 8'h01, 0, 0, 0, 0, "R7 az not taken");
    send(6, 8'h70, 8'hF0, 0, 16'h3000, 8'h80, 0, 0, 0, 0, "R7 anz taken");
    send(7, 8'h40, 8'h20, 0, 16'h3000, 0, 0, 1, 0, 0, "R7 cy taken");
    send(8, 8'h50, 8'h20, 0, 16'h3000, 0, 0, 1, 0, 0, "R7 ncy not taken");

    stall_on = 1'b1;
    // R8: bit tests and clear
    send(9, 8'h20, 8'h21, 8'h05, 16'h5000, 0, 0, 0, 1, 0, "R8 bset taken");
    send(10, 8'h30, 8'h21, 8'h05, 16'h5000, 0, 0, 0, 1, 0, "R8 bclr not taken");
    send(11, 8'h10, 8'h21, 8'hFB, 16'h5000, 0, 0, 0, 1, 0, "R8 bsetc taken clears");
    send(11, 8'h10, 8'h21, 8'hFB, 16'h5000, 0, 0, 0, 0, 0, "R8 bsetc not taken");
    // R9: loops
    send(12, 8'hD8, 8'hFE, 0, 16'h6000, 0, 0, 0, 0, 8'h01, "R9 loop reaches zero");
    send(12, 8'hD8, 8'hFE, 0, 16'h6000, 0, 0, 0, 0, 8'h00, "R9 loop wraps 255");
    send(13, 8'hD5, 8'h30, 8'hFD, 16'h6000, 0, 0, 0, 0, 8'h05, "R9 direct loop");
    // R10: compare
    send(14, 8'hB4, 8'h40, 8'h10, 16'h7000, 0, 0, 1, 0, 8'h40, "R10 cmp equal");
    send(14, 8'hB4, 8'h40, 8'h10, 16'h7000, 0, 0, 0, 0, 8'h3F, "R10 cmp lower");
    send(14, 8'hB4, 8'h40, 8'hF0, 16'h7000, 0, 0, 1, 0, 8'hC0, "R10 cmp higher");
    // R11: back-to-back under stalls
    for (int k = 0; k < 8; k++)
      send(3, 8'h80, k * 16, 0, k * 4099, 0, 0, 0, 0, 0, "R11 stream order");
    stall_on = 1'b0;

    repeat (20) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11 drained act=%0d exp=0", exp_q.size());
    end
    summary();
  end
endmodule